// File: doc/BRIEF.md
# Triplexed LCD Segment Driver

This block drives a liquid-crystal panel whose segments are arranged on three shared backplanes at one-third bias. Every segment line crosses all three backplanes, so one line carries three segments, one at each crossing. A bitmap supplies the on or off state of every crossing. The block emits a 2-bit level code for every backplane and every segment line. The code picks one of four taps on an external ladder of three equal resistors: ground, one third, two thirds or full supply.

A slot tick, derived from the system clock elsewhere, steps the block through six time slots per frame. Slots 0 to 2 give each backplane its active slot in normal polarity. Slots 3 to 5 repeat the scan with every level mirrored, so each line averages to zero DC across a frame. An unselected crossing always sees one third of the supply, and a selected ON crossing sees the full supply. The bitmap is captured only when the frame restarts, so a display update never tears within a frame.

Top module: `tri_lcd_drv`

## Requirements
- R1: After reset the block is in slot 0 with an all-off bitmap: backplane 0 drives code 2'b11, the other backplanes drive 2'b01, and every segment line drives 2'b10.
- R2: Each clock cycle with `slot_tick_i` high advances the slot by one, from 5 back to 0. With the tick low, no output changes.
- R3: In slots 0 to 2 the active backplane (index equal to the slot) drives 2'b11 (full supply) and the others drive 2'b01 (one third).
- R4: In slots 3 to 5 the active backplane (index equal to slot minus 3) drives 2'b00 (ground) and the others drive 2'b10 (two thirds).
- R5: In slots 0 to 2, segment line s drives 2'b00 if bitmap bit (active backplane × NUM_SEG + s) is set, otherwise 2'b10.
- R6: In slots 3 to 5, segment line s drives 2'b11 if that bitmap bit is set, otherwise 2'b01.
- R7: `seg_map_i` is sampled only on the tick that moves the slot from 5 to 0. Bitmap changes at any other time have no effect on the outputs.
- R8: Within a frame, every output's code in slot k+3 equals 3 minus its code in slot k, for k = 0 to 2.
- R9: Across every backplane and segment-line crossing, the level difference is exactly three steps for an ON crossing of the active backplane, and exactly one step for every other crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_tick_i | input | 1 | One-cycle pulse that advances the time slot |
| seg_map_i | input | NUM_BP*NUM_SEG | Segment bitmap; bit b*NUM_SEG+s is the crossing of backplane b and line s |
| bp_lvl_o | output | 2*NUM_BP | Level code per backplane, backplane b in bits [2b+1:2b] |
| seg_lvl_o | output | 2*NUM_SEG | Level code per segment line, line s in bits [2s+1:2s] |

## Verification
The assertions take for granted that the slot tick is a plain enable. They allow it to stay high for several cycles in a row and then expect one slot step per cycle. They also take for granted that the bitmap may change in any cycle. Only the sample taken on the wrapping tick may ever reach the outputs. The stimulus draws a fresh random bitmap at every tick and inserts random idle gaps. It adds a multi-cycle tick burst and the all-on, all-off and alternating patterns. This keeps it within those assumptions while probing the frame-boundary capture.

// File: rtl/tri_lcd_pkg.sv
package tri_lcd_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_GND = 2'b00;
  localparam lvl_t LVL_LO  = 2'b01;
  localparam lvl_t LVL_HI  = 2'b10;
  localparam lvl_t LVL_TOP = 2'b11;
endpackage

// File: rtl/tri_lcd_rst_sync.sv
module tri_lcd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/tri_lcd_slot_seq.sv
module tri_lcd_slot_seq #(
  parameter int NUM_BP = 3,
  localparam int NUM_SLOT = 2 * NUM_BP,
  localparam int SLOT_W = $clog2(NUM_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [NUM_BP-1:0] act_o,
  output logic              inv_o,
  output logic              wrap_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;
  logic [SLOT_W-1:0] phase;
  logic              last;

  assign last = (slot_q == SLOT_W'(NUM_SLOT - 1));

  always_comb begin
    if (last) begin
      slot_d = '0;
    end else begin
      slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
    end else if (tick_i) begin
      slot_q <= slot_d;
    end
  end

  always_comb begin
    inv_o = (slot_q >= SLOT_W'(NUM_BP));
    if (inv_o) begin
      phase = slot_q - SLOT_W'(NUM_BP);
    end else begin
      phase = slot_q;
    end
  end

  for (genvar b = 0; b < NUM_BP; b++) begin : g_act
    assign act_o[b] = (phase == SLOT_W'(b));
  end

  assign wrap_o = tick_i & last;
  assign slot_o = slot_q;
endmodule

// File: rtl/tri_lcd_map_reg.sv
module tri_lcd_map_reg #(
  parameter int MAP_W = 39
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MAP_W-1:0] map_i,
  output logic [MAP_W-1:0] map_o
);
  logic [MAP_W-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
    end else if (load_i) begin
      map_q <= map_i;
    end
  end

  assign map_o = map_q;
endmodule

// File: rtl/tri_lcd_lvl_gen.sv
module tri_lcd_lvl_gen
  import tri_lcd_pkg::*;
#(
  parameter int NUM_BP  = 3,
  parameter int NUM_SEG = 13,
  localparam int MAP_W = NUM_BP * NUM_SEG
) (
  input  logic [MAP_W-1:0]     map_i,
  input  logic [NUM_BP-1:0]    act_i,
  input  logic                 inv_i,
  output logic [2*NUM_BP-1:0]  bp_lvl_o,
  output logic [2*NUM_SEG-1:0] seg_lvl_o
);
  lvl_t bp_act_lvl, bp_idle_lvl, seg_on_lvl, seg_off_lvl;

  always_comb begin
    if (inv_i) begin
      bp_act_lvl  = LVL_GND;
      bp_idle_lvl = LVL_HI;
      seg_on_lvl  = LVL_TOP;
      seg_off_lvl = LVL_LO;
    end else begin
      bp_act_lvl  = LVL_TOP;
      bp_idle_lvl = LVL_LO;
      seg_on_lvl  = LVL_GND;
      seg_off_lvl = LVL_HI;
    end
  end

  for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
    assign bp_lvl_o[2*b +: 2] = act_i[b] ? bp_act_lvl : bp_idle_lvl;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_BP-1:0] col;
    logic              on;
    for (genvar b = 0; b < NUM_BP; b++) begin : g_col
      assign col[b] = map_i[b*NUM_SEG + s];
    end
    assign on = |(col & act_i);
    assign seg_lvl_o[2*s +: 2] = on ? seg_on_lvl : seg_off_lvl;
  end
endmodule

// File: rtl/tri_lcd_drv.sv
module tri_lcd_drv #(
  parameter int NUM_BP  = 3,
  parameter int NUM_SEG = 13
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        slot_tick_i,
  input  logic [NUM_BP*NUM_SEG-1:0]   seg_map_i,
  output logic [2*NUM_BP-1:0]         bp_lvl_o,
  output logic [2*NUM_SEG-1:0]        seg_lvl_o
);
  localparam int NUM_SLOT = 2 * NUM_BP;
  localparam int SLOT_W   = $clog2(NUM_SLOT);
  localparam int MAP_W    = NUM_BP * NUM_SEG;

  logic              rst_sync_n;
  logic [SLOT_W-1:0] slot_q;
  logic [NUM_BP-1:0] act;
  logic              inv;
  logic              wrap;
  logic [MAP_W-1:0]  map_q;

  tri_lcd_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tri_lcd_slot_seq #(.NUM_BP(NUM_BP)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_i (slot_tick_i),
    .slot_o (slot_q),
    .act_o  (act),
    .inv_o  (inv),
    .wrap_o (wrap)
  );

  tri_lcd_map_reg #(.MAP_W(MAP_W)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .load_i (wrap),
    .map_i  (seg_map_i),
    .map_o  (map_q)
  );

  tri_lcd_lvl_gen #(.NUM_BP(NUM_BP), .NUM_SEG(NUM_SEG)) u_lvl (
    .map_i     (map_q),
    .act_i     (act),
    .inv_i     (inv),
    .bp_lvl_o  (bp_lvl_o),
    .seg_lvl_o (seg_lvl_o)
  );
endmodule

// File: rtl/tri_lcd_drv_chk.sv
module tri_lcd_drv_chk #(
  parameter int NUM_BP  = 3,
  parameter int NUM_SEG = 13,
  localparam int NUM_SLOT = 2 * NUM_BP,
  localparam int SLOT_W = $clog2(NUM_SLOT),
  localparam int MAP_W = NUM_BP * NUM_SEG
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 slot_tick_i,
  input logic [MAP_W-1:0]     seg_map_i,
  input logic [SLOT_W-1:0]    slot_q,
  input logic [MAP_W-1:0]     map_q,
  input logic [2*NUM_BP-1:0]  bp_lvl_o,
  input logic [2*NUM_SEG-1:0] seg_lvl_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOT - 1);

  function automatic logic bp_ok(input logic [SLOT_W-1:0] sl,
                                 input logic [2*NUM_BP-1:0] bp);
    logic ok;
    logic inv;
    int   ph;
    ok  = 1'b1;
    inv = (int'(sl) >= NUM_BP);
    ph  = inv ? int'(sl) - NUM_BP : int'(sl);
    for (int b = 0; b < NUM_BP; b++) begin
      if (b == ph) ok &= (bp[2*b +: 2] == (inv ? 2'b00 : 2'b11));
      else         ok &= (bp[2*b +: 2] == (inv ? 2'b10 : 2'b01));
    end
    return ok;
  endfunction

  function automatic logic cells_ok(input logic [MAP_W-1:0] mp,
                                    input logic [2*NUM_BP-1:0] bp,
                                    input logic [2*NUM_SEG-1:0] sg);
    logic ok;
    logic act;
    int   d;
    ok = 1'b1;
    for (int b = 0; b < NUM_BP; b++) begin
      act = (bp[2*b +: 2] == 2'b00) || (bp[2*b +: 2] == 2'b11);
      for (int s = 0; s < NUM_SEG; s++) begin
        d = int'(bp[2*b +: 2]) - int'(sg[2*s +: 2]);
        if (d < 0) d = -d;
        if (act && mp[b*NUM_SEG + s]) ok &= (d == 3);
        else                          ok &= (d == 1);
      end
    end
    return ok;
  endfunction

  // R2
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST);

  // R2
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_tick_i |=> slot_q == (($past(slot_q) == LAST) ? '0 : $past(slot_q) + 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_tick_i |=> $stable(bp_lvl_o) && $stable(seg_lvl_o));

  // R7
  map_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slot_tick_i && slot_q == LAST) |=> $stable(map_q));

  // R7
  map_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_tick_i && slot_q == LAST) |=> map_q == $past(seg_map_i));

  // R3 R4
  bp_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_ok(slot_q, bp_lvl_o));

  // R9
  cell_bias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cells_ok(map_q, bp_lvl_o, seg_lvl_o));
endmodule

bind tri_lcd_drv tri_lcd_drv_chk #(.NUM_BP(NUM_BP), .NUM_SEG(NUM_SEG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .slot_tick_i (slot_tick_i),
  .seg_map_i   (seg_map_i),
  .slot_q      (slot_q),
  .map_q       (map_q),
  .bp_lvl_o    (bp_lvl_o),
  .seg_lvl_o   (seg_lvl_o)
);

// File: tb/tb_tri_lcd_drv.sv
module tb_tri_lcd_drv;
  localparam int NUM_BP  = 3;
  localparam int NUM_SEG = 13;
  localparam int MAP_W   = NUM_BP * NUM_SEG;
  localparam int OUT_W   = 2 * (NUM_BP + NUM_SEG);

  logic                   clk;
  logic                   rst_n;
  logic                   tick;
  logic [MAP_W-1:0]       seg_map;
  logic [2*NUM_BP-1:0]    bp_lvl;
  logic [2*NUM_SEG-1:0]   seg_lvl;

  int n_run;
  int n_fail;
  int slot_m;
  logic [MAP_W-1:0] map_m;
  logic [OUT_W-1:0] rec [3];

  tri_lcd_drv #(.NUM_BP(NUM_BP), .NUM_SEG(NUM_SEG)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .slot_tick_i (tick),
    .seg_map_i   (seg_map),
    .bp_lvl_o    (bp_lvl),
    .seg_lvl_o   (seg_lvl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2*NUM_BP-1:0] bp_exp(input int sl);
    logic [2*NUM_BP-1:0] v;
    logic inv;
    inv = (sl >= NUM_BP);
    for (int b = 0; b < NUM_BP; b++) begin
      if (b == sl % NUM_BP) v[2*b +: 2] = inv ? 2'b00 : 2'b11;
      else                  v[2*b +: 2] = inv ? 2'b10 : 2'b01;
    end
    return v;
  endfunction

  function automatic logic [2*NUM_SEG-1:0] seg_exp(input int sl,
                                                   input logic [MAP_W-1:0] mp);
    logic [2*NUM_SEG-1:0] v;
    logic inv;
    logic on;
    inv = (sl >= NUM_BP);
    for (int s = 0; s < NUM_SEG; s++) begin
      on = mp[(sl % NUM_BP)*NUM_SEG + s];
      if (inv) v[2*s +: 2] = on ? 2'b11 : 2'b01;
      else     v[2*s +: 2] = on ? 2'b00 : 2'b10;
    end
    return v;
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_slot();
    logic [2*NUM_BP-1:0]  eb;
    logic [2*NUM_SEG-1:0] es;
    eb = bp_exp(slot_m);
    es = seg_exp(slot_m, map_m);
    chk(bp_lvl == eb, (slot_m < NUM_BP) ? "R3 backplane" : "R4 backplane",
        64'(bp_lvl), 64'(eb));
    chk(seg_lvl == es, (slot_m < NUM_BP) ? "R5 segment" : "R6 segment",
        64'(seg_lvl), 64'(es));
    if (slot_m < NUM_BP) begin
      rec[slot_m] = {bp_lvl, seg_lvl};
    end else begin
      // R8: mirrored half of the frame
      chk({bp_lvl, seg_lvl} == ~rec[slot_m - NUM_BP], "R8 mirror",
          64'({bp_lvl, seg_lvl}), 64'(~rec[slot_m - NUM_BP]));
    end
  endtask

  task automatic model_step(input logic [MAP_W-1:0] nm);
    if (slot_m == 2*NUM_BP - 1) map_m = nm;
    slot_m = (slot_m + 1) % (2*NUM_BP);
  endtask

  task automatic do_tick(input logic [MAP_W-1:0] nm);
    @(negedge clk);
    seg_map = nm;
    tick    = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_step(nm);
    check_slot();
  endtask

  function automatic logic [MAP_W-1:0] rnd_map();
    logic [63:0] r;
    r = {$urandom, $urandom};
    return r[MAP_W-1:0];
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    logic [2*NUM_BP-1:0]  hb;
    logic [2*NUM_SEG-1:0] hs;
    logic [MAP_W-1:0]     alt;
    void'($urandom(32'd2024));
    n_run = 0;
    n_fail = 0;
    tick = 1'b0;
    seg_map = '0;
    rst_n = 1'b0;
    slot_m = 0;
    map_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(bp_lvl == 6'b010111, "R1 backplane reset", 64'(bp_lvl), 64'h17);
    chk(seg_lvl == {NUM_SEG{2'b10}}, "R1 segment reset", 64'(seg_lvl),
        64'({NUM_SEG{2'b10}}));
    check_slot();

    // R2: no tick, no change, even with a new bitmap on the input
    hb = bp_lvl;
    hs = seg_lvl;
    seg_map = '1;
    repeat (20) @(negedge clk);
    chk(bp_lvl == hb && seg_lvl == hs, "R2 idle hold",
        64'({bp_lvl, seg_lvl}), 64'({hb, hs}));

    // R7: all-on offered during the first frame must not show until slot 0
    for (int i = 0; i < 5; i++) do_tick('1);
    do_tick('1);
    for (int i = 0; i < 6; i++) do_tick('0);
    for (int i = 0; i < 6; i++) do_tick('0);

    // directed alternating pattern
    alt = '0;
    for (int i = 0; i < MAP_W; i += 2) alt[i] = 1'b1;
    for (int i = 0; i < 6; i++) do_tick(alt);
    for (int i = 0; i < 6; i++) do_tick(~alt);
    for (int i = 0; i < 6; i++) do_tick(~alt);

    // R2: tick held high several cycles, one step per cycle
    @(negedge clk);
    seg_map = alt;
    tick = 1'b1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      model_step(alt);
      check_slot();
    end
    tick = 1'b0;
    @(negedge clk);
    check_slot();

    // random bitmaps at every tick, random idle gaps
    for (int i = 0; i < 120; i++) begin
      logic [MAP_W-1:0] nm;
      nm = rnd_map();
      repeat ($urandom_range(0, 3)) @(negedge clk);
      do_tick(nm);
      // R7: mid-frame bitmap change seen at the input has no effect
      seg_map = ~nm;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule